// File: doc/BRIEF.md
# Counting Semaphore Cell

This block holds one 16-bit counting semaphore that a set of requesters share. Each requester sends a single-cycle request carrying a view code, a direction and its own identifier. A read is the take operation and a write is the release operation. The view code chooses between a take that parks the requester when the count is exhausted and a take that only tries and never parks. Every accepted request gets a response one cycle later. A read response carries the count as it stood before the operation, and a stall flag tells a parked requester to stop and wait.

Parked requesters are kept as a bitmask with one bit per requester identifier. Any release frees all of them together. A one-cycle wake pulse carries the mask of the freed requesters, and the bench or the scheduler around the block restarts them from that mask. A separate input marks the cell as a queue-typed cell. In that case take and release requests are still answered, but they change nothing and read data is zero.

A release carries no data operand: it only counts. The scheduling of threads is left to the logic around the block.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the parked mask is empty, and rsp_vld and wake_pulse are low.
- R2: Only view code 4 (take that parks) and view code 5 (take that only tries) are accepted. A request with any other view code gets no response and changes neither the count nor the parked mask.
- R3: A take while the count is above 0 returns the count from before the operation in rsp_data, with rsp_stall low, and lowers the count by one. This holds for both view codes.
- R4: A take with view code 4 while the count is 0 returns rsp_data 0 with rsp_stall high. It sets bit req_id of the parked mask and leaves the count at 0.
- R5: A take with view code 5 while the count is 0 returns rsp_data 0 with rsp_stall low. It leaves the count at 0 and the parked mask unchanged.
- R6: A release (req_wr high, view code 4 or 5) raises the count by one. If the count is already 0xFFFF, the count holds at 0xFFFF.
- R7: A release while the parked mask is non-empty gives a wake_pulse one cycle long, with wake_mask equal to the parked mask. The parked mask reads empty in that same cycle. A release with no parked requester gives no pulse.
- R8: While fifo_mode is high, a take returns rsp_data 0 with rsp_stall low. A release is answered too. Neither a take nor a release changes the count or the parked mask.
- R9: rsp_vld is high exactly one cycle after each accepted request. A release response carries rsp_data 0 and rsp_stall low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe, one request per cycle |
| req_view | input | 4 | View code: 4 = take that parks, 5 = take that only tries |
| req_wr | input | 1 | 1 = release (write), 0 = take (read) |
| req_id | input | 3 | Requester identifier |
| fifo_mode | input | 1 | Cell is queue-typed: take and release become no-ops |
| rsp_vld | output | 1 | Response valid, one cycle after an accepted request |
| rsp_data | output | 16 | Count before the take, else 0 |
| rsp_stall | output | 1 | Requester has been parked |
| waiters | output | 8 | Parked requester mask, bit per identifier |
| wake_pulse | output | 1 | One-cycle pulse when parked requesters are freed |
| wake_mask | output | 8 | Requesters freed by this pulse |

## Verification
The hardest state to reach from the ports is a count resting at its ceiling. Getting there takes 65535 releases before the saturating hold can be seen. The bench holds the request strobe high on a release for a little over 65536 back-to-back cycles. It then reads the count back with non-parking takes. A release with several parked requesters is set up by issuing parking takes from different identifiers while the count is 0, before a single release frees them all.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

  localparam int unsigned VIEW_W = 4;

  localparam logic [VIEW_W-1:0] VIEW_TAKE_PARK = 4'd4;
  localparam logic [VIEW_W-1:0] VIEW_TAKE_TRY  = 4'd5;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_TAKE_PARK = 3'd1,
    OP_TAKE_TRY  = 3'd2,
    OP_GIVE      = 3'd3,
    OP_TYPED_RD  = 3'd4,
    OP_TYPED_WR  = 3'd5
  } sem_op_e;

  function automatic logic op_is_take(input sem_op_e op);
    return (op == OP_TAKE_PARK) || (op == OP_TAKE_TRY);
  endfunction

endpackage

// File: rtl/sem_cell_decode.sv
module sem_cell_decode
  import sem_cell_pkg::*;
(
  input  logic              req_vld,
  input  logic [VIEW_W-1:0] req_view,
  input  logic              req_wr,
  input  logic              fifo_mode,
  output sem_op_e           op
);

  logic view_ok;

  assign view_ok = (req_view == VIEW_TAKE_PARK) || (req_view == VIEW_TAKE_TRY);

  always_comb begin
    op = OP_IDLE;
    if (req_vld && view_ok) begin
      if (fifo_mode) begin
        op = req_wr ? OP_TYPED_WR : OP_TYPED_RD;
      end else if (req_wr) begin
        op = OP_GIVE;
      end else if (req_view == VIEW_TAKE_PARK) begin
        op = OP_TAKE_PARK;
      end else begin
        op = OP_TAKE_TRY;
      end
    end
  end

endmodule

// File: rtl/sem_cell_counter.sv
module sem_cell_counter
  import sem_cell_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sem_op_e          op,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero,
  output logic             cnt_full,
  output logic             dec_evt,
  output logic             inc_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] f_take(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] f_give(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_d;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_full = (cnt_q == CNT_MAX);
  assign dec_evt  = op_is_take(op) && !cnt_zero;
  assign inc_evt  = (op == OP_GIVE) && !cnt_full;

  always_comb begin
    cnt_d = cnt_q;
    if (op_is_take(op)) begin
      cnt_d = f_take(cnt_q);
    end else if (op == OP_GIVE) begin
      cnt_d = f_give(cnt_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sem_cell_waiters.sv
module sem_cell_waiters
  import sem_cell_pkg::*;
#(
  parameter int unsigned N_REQ = 8,
  parameter int unsigned ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sem_op_e          op,
  input  logic             cnt_zero,
  input  logic [ID_W-1:0]  req_id,
  output logic [N_REQ-1:0] waiters_q,
  output logic             wake_pulse_q,
  output logic [N_REQ-1:0] wake_mask_q,
  output logic             park_evt,
  output logic             wake_evt
);

  function automatic logic [N_REQ-1:0] f_id_bit(input logic [ID_W-1:0] id);
    return N_REQ'(1) << id;
  endfunction

  logic [N_REQ-1:0] waiters_d;

  assign park_evt = (op == OP_TAKE_PARK) && cnt_zero;
  assign wake_evt = (op == OP_GIVE) && (waiters_q != '0);

  always_comb begin
    waiters_d = waiters_q;
    if (wake_evt) begin
      waiters_d = '0;
    end else if (park_evt) begin
      waiters_d = waiters_q | f_id_bit(req_id);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiters_q    <= '0;
      wake_pulse_q <= 1'b0;
      wake_mask_q  <= '0;
    end else begin
      waiters_q    <= waiters_d;
      wake_pulse_q <= wake_evt;
      wake_mask_q  <= wake_evt ? waiters_q : '0;
    end
  end

endmodule

// File: rtl/sem_cell_resp.sv
module sem_cell_resp
  import sem_cell_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sem_op_e          op,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             cnt_zero,
  output logic             rsp_vld,
  output logic [CNT_W-1:0] rsp_data,
  output logic             rsp_stall
);

  logic [CNT_W-1:0] data_d;
  logic             stall_d;

  always_comb begin
    data_d  = op_is_take(op) ? cnt_q : '0;
    stall_d = (op == OP_TAKE_PARK) && cnt_zero;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_data  <= '0;
      rsp_stall <= 1'b0;
    end else begin
      rsp_vld   <= (op != OP_IDLE);
      rsp_data  <= data_d;
      rsp_stall <= stall_d;
    end
  end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_cell_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_REQ = 8,
  parameter int unsigned ID_W  = $clog2(N_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [VIEW_W-1:0] req_view,
  input  logic              req_wr,
  input  logic [ID_W-1:0]   req_id,
  input  logic              fifo_mode,
  output logic              rsp_vld,
  output logic [CNT_W-1:0]  rsp_data,
  output logic              rsp_stall,
  output logic [N_REQ-1:0]  waiters,
  output logic              wake_pulse,
  output logic [N_REQ-1:0]  wake_mask
);

  sem_op_e          op_w;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;
  logic             cnt_full;
  logic             dec_evt;
  logic             inc_evt;
  logic             park_evt;
  logic             wake_evt;

  sem_cell_decode u_decode (
    .req_vld   (req_vld),
    .req_view  (req_view),
    .req_wr    (req_wr),
    .fifo_mode (fifo_mode),
    .op        (op_w)
  );

  sem_cell_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op_w),
    .cnt_q    (cnt_q),
    .cnt_zero (cnt_zero),
    .cnt_full (cnt_full),
    .dec_evt  (dec_evt),
    .inc_evt  (inc_evt)
  );

  sem_cell_waiters #(.N_REQ(N_REQ), .ID_W(ID_W)) u_waiters (
    .clk          (clk),
    .rst_n        (rst_n),
    .op           (op_w),
    .cnt_zero     (cnt_zero),
    .req_id       (req_id),
    .waiters_q    (waiters),
    .wake_pulse_q (wake_pulse),
    .wake_mask_q  (wake_mask),
    .park_evt     (park_evt),
    .wake_evt     (wake_evt)
  );

  sem_cell_resp #(.CNT_W(CNT_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op_w),
    .cnt_q     (cnt_q),
    .cnt_zero  (cnt_zero),
    .rsp_vld   (rsp_vld),
    .rsp_data  (rsp_data),
    .rsp_stall (rsp_stall)
  );

endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk
  import sem_cell_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_REQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input sem_op_e          op,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cnt_full,
  input logic             dec_evt,
  input logic             inc_evt,
  input logic             park_evt,
  input logic             wake_evt,
  input logic             rsp_vld,
  input logic [CNT_W-1:0] rsp_data,
  input logic             rsp_stall,
  input logic [N_REQ-1:0] waiters,
  input logic             wake_pulse,
  input logic [N_REQ-1:0] wake_mask
);

  AST_TAKE_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> (cnt_q == $past(cnt_q) - 1'b1));  // R3
  AST_GIVE_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> (cnt_q == $past(cnt_q) + 1'b1));  // R6
  AST_GIVE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_GIVE) && cnt_full) |=> cnt_full);  // R6
  AST_PARK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    park_evt |=> (rsp_vld && rsp_stall && (rsp_data == '0) && (cnt_q == '0)));  // R4
  AST_TRY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TAKE_TRY) |=> !rsp_stall);  // R5
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (wake_pulse && (waiters == '0) && (wake_mask != '0)));  // R7
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);  // R7
  AST_TYPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_TYPED_RD) || (op == OP_TYPED_WR)) |=>
      ($stable(cnt_q) && $stable(waiters) && (rsp_data == '0) && !rsp_stall));  // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> (!rsp_vld && $stable(cnt_q)));  // R2
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_IDLE) |=> rsp_vld);  // R9

endmodule

bind sem_cell sem_cell_chk #(.CNT_W(CNT_W), .N_REQ(N_REQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op         (op_w),
  .cnt_q      (cnt_q),
  .cnt_full   (cnt_full),
  .dec_evt    (dec_evt),
  .inc_evt    (inc_evt),
  .park_evt   (park_evt),
  .wake_evt   (wake_evt),
  .rsp_vld    (rsp_vld),
  .rsp_data   (rsp_data),
  .rsp_stall  (rsp_stall),
  .waiters    (waiters),
  .wake_pulse (wake_pulse),
  .wake_mask  (wake_mask)
);

// File: tb/sem_cell_tb.sv
`timescale 1ns/1ps
module sem_cell_tb;

  localparam int CNT_W = 16;
  localparam int N_REQ = 8;
  localparam int ID_W  = 3;
  localparam logic [3:0] V_PARK = 4'd4;
  localparam logic [3:0] V_TRY  = 4'd5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_vld = 1'b0;
  logic [3:0]       req_view = '0;
  logic             req_wr = 1'b0;
  logic [ID_W-1:0]  req_id = '0;
  logic             fifo_mode = 1'b0;
  logic             rsp_vld;
  logic [CNT_W-1:0] rsp_data;
  logic             rsp_stall;
  logic [N_REQ-1:0] waiters;
  logic             wake_pulse;
  logic [N_REQ-1:0] wake_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sem_cell u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_view(req_view),
    .req_wr(req_wr), .req_id(req_id), .fifo_mode(fifo_mode),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .rsp_stall(rsp_stall),
    .waiters(waiters), .wake_pulse(wake_pulse), .wake_mask(wake_mask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request, outputs sampled 1 ns after the accepting edge
  task automatic send(input logic [3:0] view, input logic wr, input int id);
    @(negedge clk);
    req_vld = 1'b1; req_view = view; req_wr = wr; req_id = id[ID_W-1:0];
    @(posedge clk); #1;
    req_vld = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    req_vld = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R1 rsp_vld", {31'b0, rsp_vld}, 32'd0);
    check("R1 waiters", {24'b0, waiters}, 32'd0);
    check("R1 wake_pulse", {31'b0, wake_pulse}, 32'd0);
    send(V_TRY, 1'b0, 0);
    check("R1 count zero", {16'b0, rsp_data}, 32'd0);
  endtask

  task automatic t_try_at_zero();
    send(V_TRY, 1'b0, 2);
    check("R5 rsp_vld", {31'b0, rsp_vld}, 32'd1);
    check("R5 data", {16'b0, rsp_data}, 32'd0);
    check("R5 no stall", {31'b0, rsp_stall}, 32'd0);
    check("R5 waiters", {24'b0, waiters}, 32'd0);
  endtask

  task automatic t_park_and_wake();
    send(V_PARK, 1'b0, 3);
    check("R4 stall", {31'b0, rsp_stall}, 32'd1);
    check("R4 data", {16'b0, rsp_data}, 32'd0);
    check("R4 waiters one", {24'b0, waiters}, 32'h08);
    send(V_PARK, 1'b0, 5);
    check("R4 waiters two", {24'b0, waiters}, 32'h28);
    send(V_TRY, 1'b1, 0);
    check("R7 wake pulse", {31'b0, wake_pulse}, 32'd1);
    check("R7 wake mask", {24'b0, wake_mask}, 32'h28);
    check("R7 waiters cleared", {24'b0, waiters}, 32'd0);
    check("R9 give rsp_vld", {31'b0, rsp_vld}, 32'd1);
    check("R9 give data", {16'b0, rsp_data}, 32'd0);
    idle_cycle();
    check("R7 pulse one cycle", {31'b0, wake_pulse}, 32'd0);
    check("R9 no rsp when idle", {31'b0, rsp_vld}, 32'd0);
    send(V_PARK, 1'b1, 0);
    check("R7 no pulse without waiters", {31'b0, wake_pulse}, 32'd0);
  endtask

  task automatic t_take_nonzero();
    // count is 2 here
    send(V_TRY, 1'b0, 1);
    check("R3 try pre-count", {16'b0, rsp_data}, 32'd2);
    check("R3 try no stall", {31'b0, rsp_stall}, 32'd0);
    send(V_PARK, 1'b0, 1);
    check("R3 park pre-count", {16'b0, rsp_data}, 32'd1);
    check("R3 park no stall", {31'b0, rsp_stall}, 32'd0);
    check("R3 no waiter", {24'b0, waiters}, 32'd0);
    send(V_TRY, 1'b0, 1);
    check("R3 reached zero", {16'b0, rsp_data}, 32'd0);
  endtask

  task automatic t_other_views();
    send(V_TRY, 1'b1, 0);               // count 1
    send(4'd0, 1'b1, 0);
    check("R2 view0 write no rsp", {31'b0, rsp_vld}, 32'd0);
    send(4'd2, 1'b0, 4);
    check("R2 view2 read no rsp", {31'b0, rsp_vld}, 32'd0);
    send(4'd15, 1'b1, 0);
    send(4'd6, 1'b0, 6);
    check("R2 waiters untouched", {24'b0, waiters}, 32'd0);
    send(V_TRY, 1'b0, 0);
    check("R2 count unchanged", {16'b0, rsp_data}, 32'd1);
    send(V_PARK, 1'b0, 4);              // count 0 -> park id 4
    send(4'd1, 1'b1, 0);
    check("R2 stray write no wake", {31'b0, wake_pulse}, 32'd0);
    check("R2 waiter kept", {24'b0, waiters}, 32'h10);
    send(V_PARK, 1'b1, 0);              // free id 4, count 1
    check("R7 wake id4", {24'b0, wake_mask}, 32'h10);
  endtask

  task automatic t_fifo_mode();
    // count is 1
    fifo_mode = 1'b1;
    send(V_TRY, 1'b0, 0);
    check("R8 typed read vld", {31'b0, rsp_vld}, 32'd1);
    check("R8 typed read data", {16'b0, rsp_data}, 32'd0);
    send(V_PARK, 1'b1, 0);
    send(V_TRY, 1'b1, 0);
    send(V_PARK, 1'b0, 7);
    check("R8 typed no stall", {31'b0, rsp_stall}, 32'd0);
    check("R8 typed no waiter", {24'b0, waiters}, 32'd0);
    fifo_mode = 1'b0;
    send(V_TRY, 1'b0, 0);
    check("R8 count held", {16'b0, rsp_data}, 32'd1);
    // count 0 now: typed park must not record
    fifo_mode = 1'b1;
    send(V_PARK, 1'b0, 2);
    check("R8 typed park at zero", {24'b0, waiters}, 32'd0);
    fifo_mode = 1'b0;
  endtask

  task automatic t_saturate();
    @(negedge clk);
    req_vld = 1'b1; req_view = V_TRY; req_wr = 1'b1; req_id = '0;
    repeat (65537) @(posedge clk);
    #1;
    req_vld = 1'b0;
    check("R6 no wake during burst", {31'b0, wake_pulse}, 32'd0);
    send(V_TRY, 1'b0, 0);
    check("R6 saturated", {16'b0, rsp_data}, 32'h0000FFFF);
    send(V_TRY, 1'b0, 0);
    check("R6 decrement after sat", {16'b0, rsp_data}, 32'h0000FFFE);
    send(V_TRY, 1'b1, 0);
    send(V_TRY, 1'b1, 0);
    send(V_TRY, 1'b0, 0);
    check("R6 held at max", {16'b0, rsp_data}, 32'h0000FFFF);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R1 rsp_vld in reset", {31'b0, rsp_vld}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_try_at_zero();
    t_park_and_wake();
    t_take_nonzero();
    t_other_views();
    t_fifo_mode();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule